// File: doc/BRIEF.md
# DRAM Refresh Command Sequencer

This block sits on the controller side of a graphics DRAM interface and owns the command pins whenever the memory is being refreshed. It accepts two requests from the host. The first is a single-cycle periodic refresh pulse. The second is a level that asks the memory to go into, and later come out of, its low-power self-refresh residency. If the main scheduler reports that any bank is still open, the sequencer first closes every bank with a precharge-all command. It then issues the refresh or self-refresh entry, and pads each operation with the idle cycles that the memory needs. While it owns the bus it holds `busy` high, so the main scheduler keeps its own commands off the pins.

All timing limits are parameters counted in clock cycles. These are the precharge recovery time (`T_RP`), the refresh cycle time (`T_RFC`), the number of NOP cycles after self-refresh entry (`T_HOLD`, at least 4) and the self-refresh exit window (`T_XSA`, 20000 or more by default). One shared down-counter times all four waits. Every timing parameter must be 2 or more.

The command pins are registered and decoded from the state the controller is entering. A command therefore appears on the pins in the cycle right after the request was sampled. The address bus is not driven during refresh, because the memory picks the bank itself. The only address line the block drives is `dram_ap`, which marks a precharge as all-bank.

States:
- `ST_IDLE`: nothing to do. A self-refresh request goes to `ST_PRE` (if a bank is open) or to `ST_SR_ENTER`. A refresh request or a held one goes to `ST_PRE` or to `ST_REF`.
- `ST_PRE` to `ST_WAIT_RP`: the precharge-all cycle, then the recovery wait.
- `ST_WAIT_RP` to `ST_REF` or `ST_SR_ENTER`: taken when the timer expires, according to which operation was accepted.
- `ST_REF` to `ST_WAIT_RFC` to `ST_IDLE`: the refresh cycle, then the refresh recovery wait.
- `ST_SR_ENTER` to `ST_SR_HOLD` to `ST_SR_RESIDE`: the entry cycle, then the NOP hold until the timer expires.
- `ST_SR_RESIDE` to `ST_SR_EXIT`: taken when the self-refresh request falls.
- `ST_SR_EXIT` to `ST_IDLE`: taken when the exit window expires.

Top module: `refresh_sequencer`

## Requirements
- R1: During and right after reset, the pins show deselect (`dram_cs_n`=1, `dram_ras_n`=1, `dram_cas_n`=1, `dram_we_n`=1), with `dram_cke`=1, `dram_ap`=0 and `busy`=0.
- R2: A refresh pulse in idle with no bank open makes the cycle after it a refresh command: CS, RAS and CAS low, WE high, `dram_cke`=1 and `dram_ap`=0.
- R3: A refresh pulse in idle with any bank open makes the cycle after it a precharge-all command: CS, RAS and WE low, CAS high, `dram_ap`=1. The refresh command follows exactly `T_RP` cycles later, and the cycles in between show deselect (CS high). `dram_ap` is high only on a precharge.
- R4: After a refresh, the pins show deselect with `busy`=1 for `T_RFC`-1 cycles, and `busy` falls `T_RFC` cycles after the refresh. A refresh pulse that arrives from the refresh cycle until the end of that window is held. It is issued exactly `T_RFC`+1 cycles after the first refresh, so two refreshes are never closer than `T_RFC`.
- R5: A self-refresh request in idle produces a self-refresh entry: the refresh pin pattern with `dram_cke`=0. The entry comes in the next cycle if no bank is open. If a bank is open, it comes `T_RP` cycles after a precharge-all issued in the next cycle.
- R6: For the `T_HOLD` cycles after entry, the pins show NOP (CS low, RAS, CAS and WE high) with `dram_cke`=0. After that they show deselect with `dram_cke`=0 for as long as the self-refresh request stays high.
- R7: When the self-refresh request falls, `dram_cke` goes to 1 in the next cycle, with deselect. Deselect and `dram_cke`=1 hold for `T_XSA` cycles counted from that cycle, and `busy` falls exactly `T_XSA` cycles after `dram_cke` rose.
- R8: Refresh pulses that arrive while a self-refresh is being entered, held or exited are dropped. No refresh command follows the exit.
- R9: If refresh and self-refresh requests arrive in the same idle cycle, the self-refresh is taken and the refresh is dropped.
- R10: If the self-refresh request falls during the entry hold, all `T_HOLD` NOP cycles are still driven. One deselect cycle with `dram_cke`=0 follows, and then the exit starts.
- R11: `busy` is high in every cycle in which CS is low or `dram_cke` is low, and it is low in idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_req | input | 1 | Single-cycle periodic refresh request |
| selfref_req | input | 1 | Level: high requests self-refresh residency, low requests exit |
| bank_open | input | NUM_BANKS | One bit per bank, high while that bank has an open row |
| busy | output | 1 | High while the sequencer owns the command pins |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_cke | output | 1 | Clock enable |
| dram_ap | output | 1 | Address line that selects all banks on a precharge |

## Verification
The refresh path is run once for every one of the 16 bank-open patterns of a four-bank setup. This separates the direct refresh (pattern zero) from the precharge-then-refresh path, and confirms the exact `T_RP` gap for each nonzero pattern. A second refresh pulse is then swept across every offset of the `T_RFC` window, which shows that a held request is issued at one fixed cycle no matter when it arrived. Self-refresh is tried with every bank pattern and with residencies of several lengths. It is also tried with refresh pulses during the residency, with both requests in the same cycle, and with the request dropped inside the entry hold. These runs separate dropping from holding, and show the hold being completed in full before the exit window is counted.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_WAIT_RP,
        ST_REF,
        ST_WAIT_RFC,
        ST_SR_ENTER,
        ST_SR_HOLD,
        ST_SR_RESIDE,
        ST_SR_EXIT
    } seq_state_t;

    typedef enum logic [1:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_PREALL,
        CMD_REFRESH
    } dram_cmd_t;

    typedef enum logic [1:0] {
        TSEL_RP,
        TSEL_RFC,
        TSEL_HOLD,
        TSEL_XSA
    } tsel_t;

    typedef enum logic {
        GOAL_AUTO,
        GOAL_SELF
    } goal_t;

endpackage

// File: rtl/refseq_timer.sv
module refseq_timer
    import refseq_pkg::*;
#(
    parameter int T_RP   = 8,
    parameter int T_RFC  = 40,
    parameter int T_HOLD = 4,
    parameter int T_XSA  = 20000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  tsel_t sel,
    output logic  zero
);

    localparam int MAX_A = (T_RP > T_RFC) ? T_RP : T_RFC;
    localparam int MAX_B = (T_HOLD > T_XSA) ? T_HOLD : T_XSA;
    localparam int TMAX  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(TMAX + 1);

    // Span lengths include the cycle in which the load happens.
    localparam logic [CW-1:0] LD_RP   = CW'(T_RP - 1);
    localparam logic [CW-1:0] LD_RFC  = CW'(T_RFC - 1);
    localparam logic [CW-1:0] LD_HOLD = CW'(T_HOLD);
    localparam logic [CW-1:0] LD_XSA  = CW'(T_XSA - 1);
    localparam logic [CW-1:0] ONE     = CW'(1);

    logic [CW-1:0] count;
    logic [CW-1:0] load_val;

    always_comb begin
        unique case (sel)
            TSEL_RP:   load_val = LD_RP;
            TSEL_RFC:  load_val = LD_RFC;
            TSEL_HOLD: load_val = LD_HOLD;
            TSEL_XSA:  load_val = LD_XSA;
            default:   load_val = LD_RP;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (count != '0) begin
            count <= count - ONE;
        end
    end

    assign zero = (count == '0);

endmodule

// File: rtl/refseq_fsm.sv
module refseq_fsm
    import refseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      refresh_req,
    input  logic      selfref_req,
    input  logic      any_open,
    input  logic      tmr_zero,
    output logic      tmr_load,
    output tsel_t     tmr_sel,
    output dram_cmd_t cmd_nx,
    output logic      cke_nx,
    output logic      busy_nx
);

    seq_state_t state, state_nx;
    goal_t      goal, goal_nx;
    logic       pend, pend_nx;
    logic       sr_active;
    logic       entering_ref;

    // Next-state logic
    always_comb begin
        state_nx = state;
        goal_nx  = goal;
        tmr_load = 1'b0;
        tmr_sel  = TSEL_RP;
        unique case (state)
            ST_IDLE: begin
                if (selfref_req) begin
                    goal_nx  = GOAL_SELF;
                    tmr_load = 1'b1;
                    if (any_open) begin
                        state_nx = ST_PRE;
                        tmr_sel  = TSEL_RP;
                    end else begin
                        state_nx = ST_SR_ENTER;
                        tmr_sel  = TSEL_HOLD;
                    end
                end else if (refresh_req || pend) begin
                    goal_nx  = GOAL_AUTO;
                    tmr_load = 1'b1;
                    if (any_open) begin
                        state_nx = ST_PRE;
                        tmr_sel  = TSEL_RP;
                    end else begin
                        state_nx = ST_REF;
                        tmr_sel  = TSEL_RFC;
                    end
                end
            end
            ST_PRE: begin
                state_nx = ST_WAIT_RP;
            end
            ST_WAIT_RP: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (goal == GOAL_SELF) begin
                        state_nx = ST_SR_ENTER;
                        tmr_sel  = TSEL_HOLD;
                    end else begin
                        state_nx = ST_REF;
                        tmr_sel  = TSEL_RFC;
                    end
                end
            end
            ST_REF: begin
                state_nx = ST_WAIT_RFC;
            end
            ST_WAIT_RFC: begin
                if (tmr_zero) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_SR_ENTER: begin
                state_nx = ST_SR_HOLD;
            end
            ST_SR_HOLD: begin
                if (tmr_zero) begin
                    state_nx = ST_SR_RESIDE;
                end
            end
            ST_SR_RESIDE: begin
                if (!selfref_req) begin
                    state_nx = ST_SR_EXIT;
                    tmr_load = 1'b1;
                    tmr_sel  = TSEL_XSA;
                end
            end
            ST_SR_EXIT: begin
                if (tmr_zero) begin
                    state_nx = ST_IDLE;
                end
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

    // Held refresh request: dropped whenever a self-refresh is under way.
    always_comb begin
        sr_active = (state == ST_SR_ENTER) || (state == ST_SR_HOLD) ||
                    (state == ST_SR_RESIDE) || (state == ST_SR_EXIT) ||
                    ((state != ST_IDLE) && (goal == GOAL_SELF)) ||
                    ((state == ST_IDLE) && selfref_req);
        entering_ref = (state_nx == ST_REF) && (state != ST_REF);
        if (sr_active) begin
            pend_nx = 1'b0;
        end else begin
            pend_nx = (pend || refresh_req) && !entering_ref;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            goal  <= GOAL_AUTO;
            pend  <= 1'b0;
        end else begin
            state <= state_nx;
            goal  <= goal_nx;
            pend  <= pend_nx;
        end
    end

    // Outputs for the state being entered; registered at the pins.
    always_comb begin
        cmd_nx  = CMD_DESEL;
        cke_nx  = 1'b1;
        busy_nx = (state_nx != ST_IDLE);
        unique case (state_nx)
            ST_PRE:       cmd_nx = CMD_PREALL;
            ST_REF:       cmd_nx = CMD_REFRESH;
            ST_SR_ENTER: begin
                cmd_nx = CMD_REFRESH;
                cke_nx = 1'b0;
            end
            ST_SR_HOLD: begin
                cmd_nx = CMD_NOP;
                cke_nx = 1'b0;
            end
            ST_SR_RESIDE: begin
                cmd_nx = CMD_DESEL;
                cke_nx = 1'b0;
            end
            default:      cmd_nx = CMD_DESEL;
        endcase
    end

endmodule

// File: rtl/refseq_pins.sv
module refseq_pins
    import refseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  dram_cmd_t cmd_nx,
    input  logic      cke_nx,
    input  logic      busy_nx,
    output logic      busy,
    output logic      cs_n,
    output logic      ras_n,
    output logic      cas_n,
    output logic      we_n,
    output logic      cke,
    output logic      ap
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cs_n  <= 1'b1;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            cke   <= 1'b1;
            ap    <= 1'b0;
        end else begin
            busy <= busy_nx;
            cke  <= cke_nx;
            unique case (cmd_nx)
                CMD_NOP: begin
                    cs_n  <= 1'b0;
                    ras_n <= 1'b1;
                    cas_n <= 1'b1;
                    we_n  <= 1'b1;
                    ap    <= 1'b0;
                end
                CMD_PREALL: begin
                    cs_n  <= 1'b0;
                    ras_n <= 1'b0;
                    cas_n <= 1'b1;
                    we_n  <= 1'b0;
                    ap    <= 1'b1;
                end
                CMD_REFRESH: begin
                    cs_n  <= 1'b0;
                    ras_n <= 1'b0;
                    cas_n <= 1'b0;
                    we_n  <= 1'b1;
                    ap    <= 1'b0;
                end
                default: begin
                    cs_n  <= 1'b1;
                    ras_n <= 1'b1;
                    cas_n <= 1'b1;
                    we_n  <= 1'b1;
                    ap    <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/refresh_sequencer.sv
module refresh_sequencer
    import refseq_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int T_RP      = 8,
    parameter int T_RFC     = 40,
    parameter int T_HOLD    = 4,
    parameter int T_XSA     = 20000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 refresh_req,
    input  logic                 selfref_req,
    input  logic [NUM_BANKS-1:0] bank_open,
    output logic                 busy,
    output logic                 dram_cs_n,
    output logic                 dram_ras_n,
    output logic                 dram_cas_n,
    output logic                 dram_we_n,
    output logic                 dram_cke,
    output logic                 dram_ap
);

    logic      any_open;
    logic      tmr_load;
    logic      tmr_zero;
    tsel_t     tmr_sel;
    dram_cmd_t cmd_nx;
    logic      cke_nx;
    logic      busy_nx;

    assign any_open = |bank_open;

    refseq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .refresh_req (refresh_req),
        .selfref_req (selfref_req),
        .any_open    (any_open),
        .tmr_zero    (tmr_zero),
        .tmr_load    (tmr_load),
        .tmr_sel     (tmr_sel),
        .cmd_nx      (cmd_nx),
        .cke_nx      (cke_nx),
        .busy_nx     (busy_nx)
    );

    refseq_timer #(
        .T_RP   (T_RP),
        .T_RFC  (T_RFC),
        .T_HOLD (T_HOLD),
        .T_XSA  (T_XSA)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .sel   (tmr_sel),
        .zero  (tmr_zero)
    );

    refseq_pins u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_nx  (cmd_nx),
        .cke_nx  (cke_nx),
        .busy_nx (busy_nx),
        .busy    (busy),
        .cs_n    (dram_cs_n),
        .ras_n   (dram_ras_n),
        .cas_n   (dram_cas_n),
        .we_n    (dram_we_n),
        .cke     (dram_cke),
        .ap      (dram_ap)
    );

endmodule

// File: rtl/refresh_sequencer_chk.sv
module refresh_sequencer_chk #(
    parameter int T_RP   = 8,
    parameter int T_RFC  = 40,
    parameter int T_HOLD = 4,
    parameter int T_XSA  = 20000
) (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic cs_n,
    input logic ras_n,
    input logic cas_n,
    input logic we_n,
    input logic cke,
    input logic ap
);

    localparam int CW = $clog2(T_RP + T_RFC + T_HOLD + T_XSA + 2);
    localparam logic [CW-1:0] RP_C   = CW'(T_RP);
    localparam logic [CW-1:0] RFC_C  = CW'(T_RFC);
    localparam logic [CW-1:0] HOLD_C = CW'(T_HOLD);
    localparam logic [CW-1:0] XSA_C  = CW'(T_XSA);
    localparam logic [CW-1:0] ONE    = CW'(1);

    logic is_nop, is_pre, is_ref;
    assign is_nop = !cs_n && ras_n && cas_n && we_n;
    assign is_pre = !cs_n && !ras_n && cas_n && !we_n;
    assign is_ref = !cs_n && !ras_n && !cas_n && we_n;

    logic          cke_q;
    logic [CW-1:0] hold_cnt;
    logic [CW-1:0] xsa_cnt;
    logic [CW-1:0] pre_cnt;
    logic [CW-1:0] ref_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cke_q    <= 1'b1;
            hold_cnt <= '0;
            xsa_cnt  <= '0;
            pre_cnt  <= '0;
            ref_cnt  <= '0;
        end else begin
            cke_q <= cke;
            if (cke_q && !cke)
                hold_cnt <= ONE;
            else if (hold_cnt != '0 && hold_cnt < HOLD_C)
                hold_cnt <= hold_cnt + ONE;
            else
                hold_cnt <= '0;
            if (!cke_q && cke)
                xsa_cnt <= ONE;
            else if (xsa_cnt != '0 && xsa_cnt < XSA_C - ONE)
                xsa_cnt <= xsa_cnt + ONE;
            else
                xsa_cnt <= '0;
            if (is_pre)
                pre_cnt <= ONE;
            else if (pre_cnt != '0 && pre_cnt < RP_C)
                pre_cnt <= pre_cnt + ONE;
            if (is_ref && cke)
                ref_cnt <= ONE;
            else if (ref_cnt != '0 && ref_cnt < RFC_C)
                ref_cnt <= ref_cnt + ONE;
        end
    end

    AST_SR_ENTRY_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> is_ref); // R5

    AST_ENTRY_HOLD_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_cnt != '0) |-> (is_nop && !cke)); // R6

    AST_EXIT_FIRST_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> cs_n); // R7

    AST_EXIT_WINDOW_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (xsa_cnt != '0) |-> (cs_n && cke)); // R7

    AST_RP_BEFORE_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && pre_cnt != '0) |-> (pre_cnt >= RP_C)); // R3

    AST_AP_ONLY_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        ap |-> is_pre); // R3

    AST_RFC_BETWEEN_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && cke && ref_cnt != '0) |-> (ref_cnt >= RFC_C)); // R4

    AST_BUSY_ON_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n || !cke) |-> busy); // R11

endmodule

bind refresh_sequencer refresh_sequencer_chk #(
    .T_RP   (T_RP),
    .T_RFC  (T_RFC),
    .T_HOLD (T_HOLD),
    .T_XSA  (T_XSA)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .cs_n  (dram_cs_n),
    .ras_n (dram_ras_n),
    .cas_n (dram_cas_n),
    .we_n  (dram_we_n),
    .cke   (dram_cke),
    .ap    (dram_ap)
);

// File: tb/refresh_sequencer_test.sv
module refresh_sequencer_test;

    localparam int NB    = 4;
    localparam int TRP   = 3;
    localparam int TRFC  = 6;
    localparam int THOLD = 4;
    localparam int TXSA  = 20;

    localparam int C_DESEL = 0;
    localparam int C_NOP   = 1;
    localparam int C_PRE   = 2;
    localparam int C_REF   = 3;
    localparam int C_OTHER = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          refresh_req = 1'b0;
    logic          selfref_req = 1'b0;
    logic [NB-1:0] bank_open = '0;
    logic          busy;
    logic          dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n, dram_cke, dram_ap;

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    refresh_sequencer #(
        .NUM_BANKS (NB),
        .T_RP      (TRP),
        .T_RFC     (TRFC),
        .T_HOLD    (THOLD),
        .T_XSA     (TXSA)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .refresh_req (refresh_req),
        .selfref_req (selfref_req),
        .bank_open   (bank_open),
        .busy        (busy),
        .dram_cs_n   (dram_cs_n),
        .dram_ras_n  (dram_ras_n),
        .dram_cas_n  (dram_cas_n),
        .dram_we_n   (dram_we_n),
        .dram_cke    (dram_cke),
        .dram_ap     (dram_ap)
    );

    function automatic int pin_cmd();
        if (dram_cs_n) return C_DESEL;
        if (dram_ras_n && dram_cas_n && dram_we_n) return C_NOP;
        if (!dram_ras_n && dram_cas_n && !dram_we_n) return C_PRE;
        if (!dram_ras_n && !dram_cas_n && dram_we_n) return C_REF;
        return C_OTHER;
    endfunction

    task automatic check_eq(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic check_pins(string tag, int cmd, int cke, int bsy);
        check_eq(tag, "command", pin_cmd(), cmd);
        check_eq(tag, "cke", int'(dram_cke), cke);
        check_eq(tag, "busy", int'(busy), bsy);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic run_refresh(logic [NB-1:0] pat);
        bank_open   = pat;
        refresh_req = 1'b1;
        step();
        refresh_req = 1'b0;
        bank_open   = '0;
        if (pat != '0) begin
            check_pins("R3", C_PRE, 1, 1);
            check_eq("R3", "ap on precharge", int'(dram_ap), 1);
            for (int k = 1; k < TRP; k++) begin
                step();
                check_pins("R3", C_DESEL, 1, 1);
            end
            step();
            check_pins("R3", C_REF, 1, 1);
        end else begin
            check_pins("R2", C_REF, 1, 1);
        end
        check_eq("R2", "ap on refresh", int'(dram_ap), 0);
        for (int k = 1; k < TRFC; k++) begin
            step();
            check_pins("R4", C_DESEL, 1, 1);
        end
        step();
        check_pins("R11", C_DESEL, 1, 0);
    endtask

    task automatic run_back_to_back(int j);
        int found;
        int odd;
        found = -1;
        odd   = 0;
        refresh_req = 1'b1;
        step();
        check_pins("R2", C_REF, 1, 1);
        refresh_req = (j == 0);
        for (int c = 1; c <= 3 * TRFC; c++) begin
            step();
            refresh_req = (c == j);
            if (pin_cmd() == C_REF && found < 0) found = c;
            else if (pin_cmd() != C_DESEL) odd++;
        end
        refresh_req = 1'b0;
        check_eq("R4", "cycle of held refresh", found, TRFC + 1);
        check_eq("R4", "unexpected commands", odd, 0);
        check_pins("R11", C_DESEL, 1, 0);
    endtask

    task automatic run_selfref(logic [NB-1:0] pat, int reside, bit pulse, bit both, string tag);
        bank_open   = pat;
        selfref_req = 1'b1;
        refresh_req = both;
        step();
        refresh_req = 1'b0;
        bank_open   = '0;
        if (pat != '0) begin
            check_pins("R5", C_PRE, 1, 1);
            for (int k = 1; k < TRP; k++) begin
                step();
                check_pins("R5", C_DESEL, 1, 1);
            end
            step();
        end
        check_pins(both ? "R9" : "R5", C_REF, 0, 1);
        for (int k = 1; k <= THOLD; k++) begin
            step();
            check_pins("R6", C_NOP, 0, 1);
        end
        for (int k = 1; k <= reside; k++) begin
            step();
            check_pins("R6", C_DESEL, 0, 1);
            refresh_req = pulse && (k == 1);
        end
        refresh_req = 1'b0;
        selfref_req = 1'b0;
        step();
        check_pins("R7", C_DESEL, 1, 1);
        for (int k = 1; k < TXSA; k++) begin
            step();
            check_pins("R7", C_DESEL, 1, 1);
        end
        step();
        check_pins("R7", C_DESEL, 1, 0);
        for (int k = 0; k < TRFC + 2; k++) begin
            step();
            check_pins(tag, C_DESEL, 1, 0);
        end
    endtask

    task automatic run_early_drop();
        selfref_req = 1'b1;
        step();
        check_pins("R10", C_REF, 0, 1);
        step();
        check_pins("R10", C_NOP, 0, 1);
        selfref_req = 1'b0;
        for (int k = 2; k <= THOLD; k++) begin
            step();
            check_pins("R10", C_NOP, 0, 1);
        end
        step();
        check_pins("R10", C_DESEL, 0, 1);
        step();
        check_pins("R10", C_DESEL, 1, 1);
        for (int k = 1; k < TXSA; k++) begin
            step();
            check_pins("R7", C_DESEL, 1, 1);
        end
        step();
        check_pins("R7", C_DESEL, 1, 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (3) step();
        check_pins("R1", C_DESEL, 1, 0);
        check_eq("R1", "ap in reset", int'(dram_ap), 0);
        rst_n = 1'b1;
        step();
        step();
        check_pins("R1", C_DESEL, 1, 0);
        check_eq("R1", "ap after reset", int'(dram_ap), 0);

        for (int pat = 0; pat < (1 << NB); pat++) run_refresh(NB'(pat));
        for (int j = 0; j < TRFC; j++) run_back_to_back(j);
        for (int pat = 0; pat < (1 << NB); pat++)
            run_selfref(NB'(pat), 1 + (pat % 3), 1'b0, 1'b0, "R11");
        run_selfref(NB'(0), 4, 1'b1, 1'b0, "R8");
        run_selfref(NB'(5), 4, 1'b1, 1'b0, "R8");
        run_selfref(NB'(0), 2, 1'b0, 1'b1, "R9");
        run_selfref(NB'(3), 2, 1'b0, 1'b1, "R9");
        run_early_drop();
        for (int k = 0; k < 4; k++) begin
            step();
            check_pins("R11", C_DESEL, 1, 0);
        end

        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual hung, expected completion");
            summary();
            $finish;
        end
    end

endmodule